// File: doc/BRIEF.md
# Reset Cause Status and Control Register

This block holds a single 32-bit register that tells software why the system last came out of reset, and lets software ask for a new reset. The register has three kinds of bits, all in the top five bit positions. Cause flags record a cold start and the two push-button causes; software clears them by writing ones. Software-trigger bits, once written with a one, stay set. When software writes a one to either trigger bit, the block sends a one-cycle reset request to the system's reset logic.

The block also counts how many reset events it has seen. The count saturates at its upper limit. Only the very first reset is reported as a cold start. The cold start is either the block's own synchronous reset or an event that arrives while the count is zero. A software cold-start request sets the count back to zero, so the reset that follows it is reported as a cold start again.

The register is read and written as the upper 32-bit word of a 64-bit slot at a parameterised base offset. The lower word reads as zero and ignores writes.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `rst` is high and right after it, `status_q` is 0x80000000 (only bit 31 set), `sys_reset_req` is 0 and `bus_rdata` is 0. The reset itself counts as the first reset event.
- R2: A write to the upper word (address BASE_ADDR+4) is first ANDed with 0xF8000000. Bits 26..0 of `status_q` always read zero, and writing ones to them has no effect.
- R3: Bits 31 (cold flag), 28 (button cold) and 27 (button warm) are write-one-to-clear. Writing 1 clears the bit and writing 0 leaves it as it was.
- R4: Bits 30 (software cold) and 29 (software warm) are set by writing 1. No register write ever clears them.
- R5: A write to the upper word with bit 30 or bit 29 set drives `sys_reset_req` high for exactly the next cycle. Every other cycle it is low.
- R6: A write to the upper word with bit 30 set sets the reset counter to zero. A write with only bit 29 set leaves the counter unchanged.
- R7: When `hw_reset_evt` is high and the counter is zero, `status_q` is loaded with 0x80000000, which clears every other bit. When the counter is not zero, the event leaves `status_q` unchanged. Each event adds one to the counter.
- R8: The counter stops at 2^CNT_W-1 instead of wrapping. Any number of further events therefore never reloads the cold flag.
- R9: A read of the upper word returns the `status_q` value from before that cycle's update on `bus_rdata`, one cycle later. A read of the lower word (BASE_ADDR) or of any other address returns 0. A write to any address other than the upper word changes nothing.
- R10: `btn_cold` high sets bit 28 at the next clock edge, and `btn_warm` high sets bit 27.
- R11: Within one cycle the updates are applied in this order: the event load first, then the register write, then the button inputs. A button held during a write that clears its bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_reset_evt | input | 1 | One pulse per system reset event seen by the block |
| btn_cold | input | 1 | Push-button cold-start cause |
| btn_warm | input | 1 | Push-button warm-start cause |
| status_q | output | 32 | Current register value |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with CNT_W = 2, so the counter reaches its limit of 3 after only a few events. Its directed part then sends eight more events in a row. A counter that wrapped would pass through zero and reload the cold flag, so this catches it. BASE_ADDR keeps its default, and random accesses are aimed at the upper word, the lower word and unrelated addresses. Because CNT_W is small, random software cold-start writes mix with counter saturation many times within a short run.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned COLD_FLAG_BIT = 31;
  localparam int unsigned SW_COLD_BIT   = 30;
  localparam int unsigned SW_WARM_BIT   = 29;
  localparam int unsigned BTN_COLD_BIT  = 28;
  localparam int unsigned BTN_WARM_BIT  = 27;

  localparam logic [DATA_W-1:0] ONE_HOT1 = {{(DATA_W-1){1'b0}}, 1'b1};

  localparam logic [DATA_W-1:0] W1C_MASK =
    (ONE_HOT1 << COLD_FLAG_BIT) | (ONE_HOT1 << BTN_COLD_BIT) | (ONE_HOT1 << BTN_WARM_BIT);
  localparam logic [DATA_W-1:0] SET_MASK =
    (ONE_HOT1 << SW_COLD_BIT) | (ONE_HOT1 << SW_WARM_BIT);
  localparam logic [DATA_W-1:0] LIVE_MASK = W1C_MASK | SET_MASK;
  localparam logic [DATA_W-1:0] COLD_ONLY = ONE_HOT1 << COLD_FLAG_BIT;

  typedef struct packed {
    logic              hit;
    logic [DATA_W-1:0] val;
  } wr_req_t;
endpackage

// File: rtl/rst_cause_decode.sv
module rst_cause_decode
  import rst_cause_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output wr_req_t           wr_o,
  output logic              rd_hit_o
);
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(4);

  logic hi_sel;

  assign hi_sel    = (bus_addr == HI_ADDR);
  assign rd_hit_o  = hi_sel;
  assign wr_o.hit  = bus_wr && hi_sel;
  assign wr_o.val  = bus_wdata & LIVE_MASK;
endmodule

// File: rtl/rst_cause_track.sv
module rst_cause_track #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic clr_i,
  output logic first_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             chk_arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_ONE;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (evt_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign first_o = (cnt_q == '0);

  always_ff @(posedge clk) chk_arm <= !rst;

  // R8
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm && $past(cnt_q == CNT_MAX && !clr_i) |-> (cnt_q == CNT_MAX));

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm && $past(clr_i) |-> first_o);
endmodule

// File: rtl/rst_cause_store.sv
module rst_cause_store
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              first_i,
  input  wr_req_t           wr_i,
  input  logic              btn_cold_i,
  input  logic              btn_warm_i,
  output logic [DATA_W-1:0] status_q
);
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] btn_set;
  logic              chk_arm;

  assign btn_set = ({{(DATA_W-1){1'b0}}, btn_cold_i} << BTN_COLD_BIT)
                 | ({{(DATA_W-1){1'b0}}, btn_warm_i} << BTN_WARM_BIT);

  always_comb begin
    nxt = status_q;
    if (evt_i && first_i) begin
      nxt = COLD_ONLY;
    end
    if (wr_i.hit) begin
      nxt = (nxt & ~(wr_i.val & W1C_MASK)) | (wr_i.val & SET_MASK);
    end
    nxt = nxt | btn_set;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= COLD_ONLY;
    else     status_q <= nxt;
  end

  always_ff @(posedge clk) chk_arm <= !rst;

  // R2
  dead_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm |-> (status_q[26:0] == '0));

  // R4
  sticky_soft_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm && $past(status_q[SW_COLD_BIT] && !evt_i) |-> status_q[SW_COLD_BIT]);

  // R7
  cold_load_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm && $past(evt_i && first_i && !wr_i.hit && !btn_cold_i && !btn_warm_i)
      |-> (status_q == COLD_ONLY));

  // R10
  btn_cold_set_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm && $past(btn_cold_i) |-> status_q[BTN_COLD_BIT]);
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int unsigned       CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_reset_evt,
  input  logic              btn_cold,
  input  logic              btn_warm,
  output logic [31:0]       status_q,
  output logic              sys_reset_req
);
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(4);

  wr_req_t wr;
  logic    rd_hit;
  logic    first;
  logic    cold_trig;
  logic    any_trig;
  logic    chk_arm;

  rst_cause_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) dec_i (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wr_o      (wr),
    .rd_hit_o  (rd_hit)
  );

  assign cold_trig = wr.hit && wr.val[SW_COLD_BIT];
  assign any_trig  = wr.hit && (wr.val[SW_COLD_BIT] || wr.val[SW_WARM_BIT]);

  rst_cause_track #(.CNT_W(CNT_W)) trk_i (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (hw_reset_evt),
    .clr_i   (cold_trig),
    .first_o (first)
  );

  rst_cause_store st_i (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (hw_reset_evt),
    .first_i    (first),
    .wr_i       (wr),
    .btn_cold_i (btn_cold),
    .btn_warm_i (btn_warm),
    .status_q   (status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_reset_req <= 1'b0;
      bus_rdata     <= '0;
    end else begin
      sys_reset_req <= any_trig;
      bus_rdata     <= (bus_rd && rd_hit) ? status_q : '0;
    end
  end

  always_ff @(posedge clk) chk_arm <= !rst;

  // R5
  req_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm && sys_reset_req |->
      $past(bus_wr && bus_addr == HI_ADDR && (bus_wdata[30] || bus_wdata[29])));

  // R9
  rdata_source_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm && (bus_rdata != '0) |-> $past(bus_rd && bus_addr == HI_ADDR));
endmodule

// File: tb/rst_cause_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb_top;
  localparam int          CNT_W = 2;
  localparam int          CMAX  = (1 << CNT_W) - 1;
  localparam logic [15:0] BASE  = 16'hF020;
  localparam logic [15:0] HI    = BASE + 16'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_reset_evt = 1'b0, btn_cold = 1'b0, btn_warm = 1'b0;
  logic [31:0] status_q;
  logic        sys_reset_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_st;
  int          exp_cnt;

  always #2.5 clk = ~clk;

  rst_cause_ctrl #(.ADDR_W(16), .BASE_ADDR(BASE), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_reset_evt(hw_reset_evt),
    .btn_cold(btn_cold), .btn_warm(btn_warm), .status_q(status_q),
    .sys_reset_req(sys_reset_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] st, input int c,
      input logic wrhi, input logic [31:0] d, input logic ev, input logic bc, input logic bw);
    logic [31:0] m = d & 32'hF800_0000;
    logic [31:0] n = st;
    if (ev && c == 0) n = 32'h8000_0000;
    if (wrhi) n = (n & ~(m & 32'h9800_0000)) | (m & 32'h6000_0000);
    if (bc) n[28] = 1'b1;
    if (bw) n[27] = 1'b1;
    return n;
  endfunction

  task automatic cyc(input logic wr, input logic rd, input logic [15:0] a,
      input logic [31:0] d, input logic ev, input logic bc, input logic bw, input string tag);
    logic        wrhi;
    logic [31:0] n_st, e_rd;
    logic        e_req;
    int          n_c;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    hw_reset_evt = ev; btn_cold = bc; btn_warm = bw;
    wrhi  = wr && (a == HI);
    n_st  = model_next(exp_st, exp_cnt, wrhi, d, ev, bc, bw);
    e_req = wrhi && (d[30] || d[29]);
    e_rd  = (rd && a == HI) ? exp_st : 32'h0;
    n_c   = exp_cnt;
    if (wrhi && d[30]) n_c = 0;
    else if (ev && n_c < CMAX) n_c = n_c + 1;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " status"}, status_q, n_st);
    chk({tag, " req"}, {31'h0, sys_reset_req}, {31'h0, e_req});
    chk({tag, " rdata"}, bus_rdata, e_rd);
    exp_st = n_st;
    exp_cnt = n_c;
    bus_wr = 1'b0; bus_rd = 1'b0; hw_reset_evt = 1'b0; btn_cold = 1'b0; btn_warm = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] ra;
    logic [31:0] rw;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status_q, 32'h8000_0000);
    chk("R1 req", {31'h0, sys_reset_req}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    exp_st = 32'h8000_0000;
    exp_cnt = 1;
    @(negedge clk);
    chk("R1 after release", status_q, 32'h8000_0000);

    cyc(1, 0, HI,   32'hFFFF_FFFF, 0, 0, 0, "R3 R4 R5");
    cyc(0, 0, HI,   32'h0,         0, 0, 0, "R5 single pulse");
    cyc(0, 1, HI,   32'h0,         0, 0, 0, "R9 upper read");
    cyc(0, 1, BASE, 32'h0,         0, 0, 0, "R9 lower read");
    cyc(1, 0, BASE, 32'hFFFF_FFFF, 0, 0, 0, "R9 lower write");
    cyc(1, 0, 16'h1234, 32'hFFFF_FFFF, 0, 0, 0, "R9 other write");
    cyc(1, 0, HI,   32'h07FF_FFFF, 0, 0, 0, "R2 mask");
    cyc(0, 0, HI,   32'h0,         1, 0, 0, "R6 R7 cold reload");
    cyc(0, 0, HI,   32'h0,         1, 0, 0, "R7 no reload");
    cyc(0, 0, HI,   32'h0,         0, 1, 0, "R10 btn cold");
    cyc(1, 0, HI,   32'h1000_0000, 0, 0, 1, "R3 R10 btn warm");
    cyc(1, 0, HI,   32'h9800_0000, 0, 1, 0, "R11 button wins");
    cyc(1, 0, HI,   32'h2000_0000, 0, 0, 0, "R5 R6 warm trigger");
    for (int i = 0; i < 8; i++) cyc(0, 0, HI, 32'h0, 1, 0, 0, "R8 saturate");
    cyc(0, 1, HI,   32'h0,         0, 0, 0, "R8 readback");
    cyc(1, 0, HI,   32'h0,         0, 0, 0, "R3 zero write");

    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 3))
        0: ra = BASE;
        1: ra = 16'($urandom);
        default: ra = HI;
      endcase
      rw = $urandom;
      if ($urandom_range(0, 3) != 0) rw[30] = 1'b0;
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, ra, rw,
          $urandom_range(0, 4) == 0, $urandom_range(0, 7) == 0,
          $urandom_range(0, 7) == 0, "R2 R3 R4 R7 R10 R11 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule